// File: doc/BRIEF.md
# Sequential Pattern-Match Trigger

This block decides when a logic capture begins. It watches a sample word that comes with a valid strobe and walks through a chain of match stages. Every stage carries a mask word, a compare word and a control word. A stage matches a sample when the masked bits of the sample equal the same masked bits of the compare word. Mask bits that are zero are "don't care" bits.

Only one stage is active at any time. A match on the active stage moves the chain to the next stage. A match on a stage whose control word has the start flag set fires the trigger instead. The stage that fires is therefore chosen by configuration. It is not always the last stage. After the trigger fires, the unit stays frozen until it is armed again.

The mask, compare and control words arrive as static flat input vectors. The surrounding logic loads them before it pulses the arm input. The outputs are a single-cycle trigger pulse and the index of the active stage.

Top module: `trig_seq`

## Requirements
- R1: After reset the stage index is 0 and the trigger output is low. Until the first arm pulse, no sample produces a trigger or changes the stage.
- R2: A stage matches when (sample AND mask) equals (compare AND mask). Sample bits outside the mask never affect the result.
- R3: Stages are compared only on cycles where the sample valid input is high. With valid low, the stage index holds and no trigger is raised.
- R4: When the active stage matches and its start flag is clear, the stage index increases by one. The next valid sample is then compared against the new stage.
- R5: The start flag is bit 3 of a stage's control word (value 0x08). When a stage with this flag matches, the trigger output is high for exactly one cycle, the cycle after the clock edge that took the sample.
- R6: With every mask zero and stage 0's control word set to 0x08, the trigger fires on the first valid sample after arming.
- R7: After the trigger fires, the stage index holds and no further trigger is raised, whatever samples arrive, until the next arm.
- R8: An arm pulse sets the stage index to 0, clears the fired condition and enables matching. When arm and valid are high in the same cycle, arm wins and the sample is not compared.
- R9: When the last stage matches and its start flag is clear, the stage index stays on the last stage and no trigger is raised.
- R10: A valid sample that does not match the active stage leaves the stage index unchanged and raises no trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | Arm pulse: restart the chain at stage 0 |
| mask_i | input | N_STAGES*DATA_W | Per-stage mask words; stage k at bits [k*DATA_W +: DATA_W] |
| value_i | input | N_STAGES*DATA_W | Per-stage compare words, same packing as the masks |
| cfg_i | input | N_STAGES*CFG_W | Per-stage control words; bit START_BIT of each word is the start flag |
| sample_i | input | DATA_W | Sample word |
| sample_vld_i | input | 1 | Sample valid strobe |
| trig_o | output | 1 | One-cycle trigger pulse |
| stage_o | output | $clog2(N_STAGES) | Index of the active stage |

## Verification
The bench builds the block with its defaults: four stages, 32-bit samples, 32-bit control words and the start flag at bit 3. With four stages, a short directed run can carry the chain through every stage and test the hold on the last stage. The full 32-bit width lets the samples set bits high in the word, outside narrow masks, to show that unmasked bits are ignored. Placing the start flag on a middle stage shows that the firing stage comes from configuration and not from position.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  typedef enum logic [1:0] {
    RUN_IDLE  = 2'd0,
    RUN_ARMED = 2'd1,
    RUN_FIRED = 2'd2
  } run_state_t;
endpackage

// File: rtl/trig_seq_match.sv
// Parallel per-stage comparators and start-flag extraction.
module trig_seq_match #(
  parameter int DATA_W    = 32,
  parameter int N_STAGES  = 4,
  parameter int CFG_W     = 32,
  parameter int START_BIT = 3
) (
  input  logic [N_STAGES*DATA_W-1:0] mask_i,
  input  logic [N_STAGES*DATA_W-1:0] value_i,
  input  logic [N_STAGES*CFG_W-1:0]  cfg_i,
  input  logic [DATA_W-1:0]          sample_i,
  output logic [N_STAGES-1:0]        hit_o,
  output logic [N_STAGES-1:0]        start_o
);
  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    logic [DATA_W-1:0] msk;
    logic [DATA_W-1:0] ref_w;
    assign msk        = mask_i[k*DATA_W +: DATA_W];
    assign ref_w      = value_i[k*DATA_W +: DATA_W];
    assign hit_o[k]   = ((sample_i & msk) == (ref_w & msk));
    assign start_o[k] = cfg_i[k*CFG_W + START_BIT];
  end

  // Control-word bits other than the start flag are reserved.
  logic cfg_unused;
  assign cfg_unused = ^cfg_i;
endmodule

// File: rtl/trig_seq_ctrl.sv
// Stage sequencer: next-state logic and registers.
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int N_STAGES = 4,
  localparam int SW = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                arm_i,
  input  logic                vld_i,
  input  logic [N_STAGES-1:0] hit_i,
  input  logic [N_STAGES-1:0] start_i,
  output logic [SW-1:0]       stage_o,
  output logic                trig_o
);
  localparam logic [SW-1:0] LAST_STAGE = SW'(N_STAGES - 1);

  run_state_t state_q, state_d;
  logic [SW-1:0] stage_q, stage_d;
  logic trig_q, trig_d;
  logic cur_hit, cur_start;

  assign cur_hit   = hit_i[stage_q];
  assign cur_start = start_i[stage_q];

  always_comb begin
    state_d = state_q;
    stage_d = stage_q;
    trig_d  = 1'b0;
    if (arm_i) begin
      state_d = RUN_ARMED;
      stage_d = '0;
    end else if (state_q == RUN_ARMED && vld_i && cur_hit) begin
      if (cur_start) begin
        state_d = RUN_FIRED;
        trig_d  = 1'b1;
      end else if (stage_q != LAST_STAGE) begin
        stage_d = stage_q + SW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RUN_IDLE;
      stage_q <= '0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      stage_q <= stage_d;
      trig_q  <= trig_d;
    end
  end

  assign stage_o = stage_q;
  assign trig_o  = trig_q;
endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int DATA_W    = 32,
  parameter int N_STAGES  = 4,
  parameter int CFG_W     = 32,
  parameter int START_BIT = 3,
  localparam int SW = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm_i,
  input  logic [N_STAGES*DATA_W-1:0] mask_i,
  input  logic [N_STAGES*DATA_W-1:0] value_i,
  input  logic [N_STAGES*CFG_W-1:0]  cfg_i,
  input  logic [DATA_W-1:0]          sample_i,
  input  logic                       sample_vld_i,
  output logic                       trig_o,
  output logic [SW-1:0]              stage_o
);
  logic [N_STAGES-1:0] hit;
  logic [N_STAGES-1:0] start;

  trig_seq_match #(
    .DATA_W(DATA_W), .N_STAGES(N_STAGES), .CFG_W(CFG_W), .START_BIT(START_BIT)
  ) u_match (
    .mask_i(mask_i), .value_i(value_i), .cfg_i(cfg_i),
    .sample_i(sample_i), .hit_o(hit), .start_o(start)
  );

  trig_seq_ctrl #(.N_STAGES(N_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .vld_i(sample_vld_i),
    .hit_i(hit), .start_i(start), .stage_o(stage_o), .trig_o(trig_o)
  );
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int N_STAGES  = 4,
  parameter int CFG_W     = 32,
  parameter int START_BIT = 3,
  localparam int SW = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      arm_i,
  input logic [N_STAGES*CFG_W-1:0] cfg_i,
  input logic                      sample_vld_i,
  input logic                      trig_o,
  input logic [SW-1:0]             stage_o
);
  logic cur_start;
  always_comb begin
    cur_start = 1'b0;
    for (int k = 0; k < N_STAGES; k++)
      if (stage_o == SW'(k)) cur_start = cfg_i[k*CFG_W + START_BIT];
  end

  AST_TRIG_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o); // R5
  AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(sample_vld_i)); // R3
  AST_TRIG_AT_START_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_o) |-> $past(cur_start)); // R5
  AST_IDLE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_vld_i && !arm_i) |=> ($stable(stage_o) && !trig_o)); // R3
  AST_STAGE_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> (stage_o == $past(stage_o) || stage_o == $past(stage_o) + SW'(1))); // R4
  AST_ARM_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (stage_o == '0 && !trig_o)); // R8
endmodule

bind trig_seq trig_seq_chk #(
  .N_STAGES(N_STAGES), .CFG_W(CFG_W), .START_BIT(START_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .cfg_i(cfg_i),
  .sample_vld_i(sample_vld_i), .trig_o(trig_o), .stage_o(stage_o)
);

// File: tb/trig_seq_test.sv
module trig_seq_test;
  localparam int W = 32;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic arm;
  logic [N*W-1:0] mask, value, cfg;
  logic [W-1:0] sample;
  logic vld;
  logic trig;
  logic [1:0] stage;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  trig_seq uut (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .mask_i(mask), .value_i(value),
    .cfg_i(cfg), .sample_i(sample), .sample_vld_i(vld),
    .trig_o(trig), .stage_o(stage)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_stage(input int k, input logic [31:0] m, input logic [31:0] v,
                           input logic [31:0] c);
    mask[k*W +: W]  = m;
    value[k*W +: W] = v;
    cfg[k*W +: W]   = c;
  endtask

  // Drive one cycle, then look just after the edge that took it.
  task automatic step(input logic [31:0] s, input logic v, input logic a);
    @(negedge clk);
    sample = s; vld = v; arm = a;
    @(posedge clk);
    #1;
    vld = 1'b0; arm = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 stage after reset", 32'(stage), 0);
    check("R1 trig after reset", 32'(trig), 0);
    for (int k = 0; k < N; k++) set_stage(k, 0, 0, 32'h8);
    step(32'h1, 1'b1, 1'b0);
    check("R1 no trigger before arm", 32'(trig), 0);
    check("R1 stage before arm", 32'(stage), 0);
  endtask

  task automatic t_first_sample;
    for (int k = 0; k < N; k++) set_stage(k, 0, 0, 0);
    set_stage(0, 0, 0, 32'h8);
    step(0, 1'b0, 1'b1);
    check("R8 stage after arm", 32'(stage), 0);
    step(32'hDEAD_BEEF, 1'b1, 1'b0);
    check("R6 fires on first valid sample", 32'(trig), 1);
    step(32'h0, 1'b0, 1'b0);
    check("R5 pulse is one cycle", 32'(trig), 0);
    step(32'h5, 1'b1, 1'b0);
    check("R7 no retrigger", 32'(trig), 0);
    check("R7 stage held", 32'(stage), 0);
  endtask

  task automatic t_sequence;
    set_stage(0, 32'h0000_00FF, 32'h0000_0011, 0);
    set_stage(1, 32'h0000_FF00, 32'h0000_2200, 0);
    set_stage(2, 32'hF000_0000, 32'hA000_0000, 32'h8);
    set_stage(3, 0, 0, 32'h8);
    step(0, 1'b0, 1'b1);
    step(32'h0000_0011, 1'b0, 1'b0);
    check("R3 no compare without valid", 32'(stage), 0);
    step(32'h0000_0012, 1'b1, 1'b0);
    check("R10 mismatch holds stage", 32'(stage), 0);
    check("R10 mismatch no trig", 32'(trig), 0);
    step(32'hFFFF_FF11, 1'b1, 1'b0);
    check("R2 unmasked bits ignored", 32'(stage), 1);
    step(32'h0000_0011, 1'b1, 1'b0);
    check("R4 next sample uses stage 1", 32'(stage), 1);
    step(32'h1234_22CD, 1'b1, 1'b0);
    check("R4 advance to stage 2", 32'(stage), 2);
    check("R4 no trig on advance", 32'(trig), 0);
    step(32'hA555_5555, 1'b1, 1'b0);
    check("R5 start stage fires", 32'(trig), 1);
    check("R7 stage stays on firing stage", 32'(stage), 2);
    step(32'hA000_0000, 1'b1, 1'b0);
    check("R7 no second trigger", 32'(trig), 0);
    check("R7 stage frozen", 32'(stage), 2);
  endtask

  task automatic t_arm_priority;
    set_stage(0, 32'hFF, 32'h11, 0);
    set_stage(1, 32'hFF, 32'h22, 32'h8);
    step(0, 1'b0, 1'b1);
    step(32'h11, 1'b1, 1'b0);
    check("R4 reached stage 1", 32'(stage), 1);
    step(32'h22, 1'b1, 1'b1);
    check("R8 arm wins over sample", 32'(stage), 0);
    check("R8 arm suppresses trig", 32'(trig), 0);
    step(32'h11, 1'b1, 1'b0);
    step(32'h22, 1'b1, 1'b0);
    check("R8 fires after re-arm", 32'(trig), 1);
    step(0, 1'b0, 1'b1);
    check("R8 re-arm clears fired stage", 32'(stage), 0);
    step(32'h11, 1'b1, 1'b0);
    step(32'h22, 1'b1, 1'b0);
    check("R8 fires again after second arm", 32'(trig), 1);
  endtask

  task automatic t_last_hold;
    for (int k = 0; k < N; k++) set_stage(k, 0, 0, 0);
    step(0, 1'b0, 1'b1);
    for (int k = 1; k < N; k++) begin
      step(32'(k), 1'b1, 1'b0);
      check("R4 walk through stages", 32'(stage), 32'(k));
    end
    step(32'h9, 1'b1, 1'b0);
    check("R9 hold on last stage", 32'(stage), 3);
    check("R9 no trig on last stage", 32'(trig), 0);
    step(32'h9, 1'b1, 1'b0);
    check("R9 still last stage", 32'(stage), 3);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; vld = 1'b0; sample = '0;
    mask = '0; value = '0; cfg = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_first_sample();
    t_sequence();
    t_arm_priority();
    t_last_hold();
    finish_run();
  end
endmodule